// File: doc/BRIEF.md
# Split-Half Transmit Byte FIFO

This block buffers bytes headed from a processor to a card data serializer. Its 16 byte slots form two halves of 8 slots each. The processor pushes bytes through a single write port, one byte per write strobe. The serializer pops one byte at a time from a show-ahead read port.

Each half has its own sticky "drained" event flag. A half's flag rises when the last byte stored in that half leaves the FIFO, and it stays set until the processor clears it with a write-one-to-clear strobe. Software may preload anywhere from 1 to 16 bytes before a transfer. After that it refills 8 bytes each time a half reports drained, while the other half keeps feeding the serializer.

A flush input empties the FIFO and drops all flags. It is used when the transfer direction changes or the controller is turned off.

Top module: `tx_halves_fifo`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `count_o` is 0, both bits of `half_drained_o` are 0 and `overflow_o` is 0.
- R2: Bytes leave in the order they were written. While the FIFO holds data, `rd_data_o` shows the oldest byte, and a read strobe removes that byte at the clock edge.
- R3: A write strobe while `count_o` is 16 is ignored, even if a read happens in the same cycle. Such a write does not change the stored bytes, and it sets `overflow_o` from the next cycle on. `overflow_o` then stays set until a flush.
- R4: A read strobe while the FIFO is empty drives `underrun_o` high in that same cycle. Such a read changes neither `count_o` nor the flags.
- R5: Storage slots 0 to 7 form half 0 and slots 8 to 15 form half 1. Writes and reads both start at slot 0 and advance one slot at a time, wrapping around. When a read removes the byte in the last slot of half h (slot 7 or slot 15), `half_drained_o[h]` is 1 from the following cycle on.
- R6: A set flag stays set until `half_clr_i[h]` is pulsed. If a clear and a set for the same half fall in the same cycle, the flag ends up set.
- R7: Drain events alternate between the halves. After reset or a flush, the first 8 reads complete half 0, the next 8 complete half 1, and the 8 after that complete half 0 again.
- R8: While `flush_i` is high, the next edge empties the FIFO and clears both flags and `overflow_o`. The next write after a flush goes to slot 0.
- R9: `count_o` equals the number of stored bytes, from 0 to 16. `full_o` is 1 exactly when the count is 16, and `empty_o` is 1 exactly when it is 0. An accepted read and an accepted write in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of pointers and flags |
| wr_en_i | input | 1 | Processor byte write strobe |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Serializer pop strobe |
| rd_data_o | output | 8 | Oldest stored byte |
| underrun_o | output | 1 | Read attempted while empty |
| count_o | output | 5 | Number of stored bytes |
| full_o | output | 1 | FIFO holds 16 bytes |
| empty_o | output | 1 | FIFO holds no bytes |
| half_clr_i | input | 2 | Write-one-to-clear strobes for the half flags |
| half_drained_o | output | 2 | Sticky per-half drained flags |
| overflow_o | output | 1 | Sticky write-while-full status |

## Verification
The bench uses the default parameters: 8-bit data, halves of 8 slots, and two halves. With this small capacity, full, overflow, and both pointer wraps come up within a few dozen cycles of biased random traffic. That makes the half alternation and the set-versus-clear collision reachable many times over in a short run. Write-heavy and read-heavy phases, plus rare flushes, move the pointers to every slot offset, so flushes happen in the middle of a half as well as at its boundary.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  parameter int unsigned TXF_DATA_W     = 8;
  parameter int unsigned TXF_HALF_DEPTH = 8;
  parameter int unsigned TXF_NUM_HALVES = 2;
endpackage

// File: rtl/txf_ptr_ctrl.sv
module txf_ptr_ctrl #(
  parameter int unsigned HALF_DEPTH = 8,
  parameter int unsigned NUM_HALVES = 2,
  localparam int unsigned DEPTH = HALF_DEPTH * NUM_HALVES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned HW    = $clog2(HALF_DEPTH),
  localparam int unsigned HIW   = AW - HW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  wr_req_i,
  input  logic                  rd_req_i,
  output logic [AW-1:0]         wr_ptr_o,
  output logic [AW-1:0]         rd_ptr_o,
  output logic [AW:0]           count_o,
  output logic                  wr_ok_o,
  output logic                  rd_ok_o,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  ovf_o,
  output logic [NUM_HALVES-1:0] half_done_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;
  logic          ovf_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok_o = wr_req_i && !full_o;
  assign rd_ok_o = rd_req_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (wr_ok_o && !rd_ok_o)      cnt_q <= cnt_q + 1'b1;
      else if (rd_ok_o && !wr_ok_o) cnt_q <= cnt_q - 1'b1;
      if (wr_req_i && full_o) ovf_q <= 1'b1;
    end
  end

  // one-cycle event when the last slot of a half is popped
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_done
    assign half_done_o[h] = rd_ok_o && (rd_ptr_q[AW-1:HW] == HIW'(h))
                            && (&rd_ptr_q[HW-1:0]);
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = cnt_q;
  assign ovf_o    = ovf_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_req_i && !rd_req_i && !flush_i) |=> (count_o == (AW+1)'(DEPTH)));
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flush_i) |=> ovf_o);
  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (AW+1)'(DEPTH));
  p_empty_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_req_i && !wr_req_i && !flush_i) |=> empty_o);
  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !ovf_o && rd_ptr_o == '0 && wr_ptr_o == '0));
endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txf_half_flag.sv
module txf_half_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats a colliding clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flush_i) flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i && !flush_i) |=> flag_o);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> flag_o);
endmodule

// File: rtl/tx_halves_fifo.sv
module tx_halves_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = TXF_DATA_W,
  parameter int unsigned HALF_DEPTH = TXF_HALF_DEPTH,
  parameter int unsigned NUM_HALVES = TXF_NUM_HALVES,
  localparam int unsigned DEPTH = HALF_DEPTH * NUM_HALVES,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  underrun_o,
  output logic [AW:0]           count_o,
  output logic                  full_o,
  output logic                  empty_o,
  input  logic [NUM_HALVES-1:0] half_clr_i,
  output logic [NUM_HALVES-1:0] half_drained_o,
  output logic                  overflow_o
);
  logic [AW-1:0]         wr_ptr, rd_ptr;
  logic                  wr_ok, rd_ok;
  logic [NUM_HALVES-1:0] half_done;

  txf_ptr_ctrl #(
    .HALF_DEPTH(HALF_DEPTH),
    .NUM_HALVES(NUM_HALVES)
  ) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_req_i   (wr_en_i),
    .rd_req_i   (rd_en_i),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .count_o    (count_o),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .ovf_o      (overflow_o),
    .half_done_o(half_done)
  );

  txf_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) i_store (
    .clk_i  (clk_i),
    .we_i   (wr_ok && !flush_i),
    .waddr_i(wr_ptr),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr),
    .rdata_o(rd_data_o)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_flag
    txf_half_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(flush_i),
      .set_i  (half_done[h]),
      .clr_i  (half_clr_i[h]),
      .flag_o (half_drained_o[h])
    );
  end

  assign underrun_o = rd_en_i && empty_o;

  p_underrun_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (empty_o && !rd_ok));
  p_one_half_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(half_done));
  p_flush_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (half_drained_o == '0));
endmodule

// File: tb/test_tx_halves_fifo.sv
module test_tx_halves_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] clr = '0;
  logic [7:0] rd_data;
  logic       underrun, full, empty, overflow;
  logic [4:0] count;
  logic [1:0] drained;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  byte unsigned q[$];
  int           pops = 0;
  logic [1:0]   m_flags = '0;
  logic         m_ovf = 1'b0;

  always #4 clk = ~clk;

  tx_halves_fifo i_tx_halves_fifo (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .underrun_o(underrun), .count_o(count), .full_o(full), .empty_o(empty),
    .half_clr_i(clr), .half_drained_o(drained), .overflow_o(overflow)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] drain_event(int p);
    logic [1:0] e;
    e = '0;
    if ((p % 8) == 7) e[(p / 8) % 2] = 1'b1;
    return e;
  endfunction

  task automatic check_state(string tag);
    check({tag, " R9"}, "count", int'(count), q.size());
    check("R9", "full", int'(full), int'(q.size() == 16));
    check("R9", "empty", int'(empty), int'(q.size() == 0));
    check("R5 R6 R7", "half_drained", int'(drained), int'(m_flags));
    check("R3", "overflow", int'(overflow), int'(m_ovf));
  endtask

  // one cycle: check registered state, drive, check comb, clock, update model
  task automatic step(bit f, bit w, byte unsigned d, bit r, logic [1:0] c);
    logic [1:0] ev;
    bit wok, rok;
    @(negedge clk);
    check_state("step");
    flush = f; wr_en = w; wr_data = d; rd_en = r; clr = c;
    #1;
    check("R4", "underrun", int'(underrun), int'(r && q.size() == 0));
    if (q.size() > 0) check("R2", "rd_data", int'(rd_data), int'(q[0]));
    @(posedge clk);
    if (f) begin
      q.delete(); pops = 0; m_flags = '0; m_ovf = 1'b0;
    end else begin
      wok = w && q.size() < 16;
      rok = r && q.size() > 0;
      ev = '0;
      if (w && q.size() == 16) m_ovf = 1'b1;
      if (rok) begin
        ev = drain_event(pops);
        pops = (pops + 1) % 16;
        void'(q.pop_front());
      end
      m_flags = (m_flags & ~c) | ev;
      if (wok) q.push_back(d);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #20;
    @(negedge clk);
    check("R1", "reset empty", int'(empty), 1);
    check("R1", "reset count", int'(count), 0);
    check("R1", "reset flags", int'(drained), 0);
    check("R1", "reset ovf", int'(overflow), 0);
    check("R1", "reset full", int'(full), 0);
    rst_n = 1'b1;

    // R4: read when empty
    step(0, 0, 0, 1, 2'b00);
    // preload 5, drain 5: no flag yet
    for (int i = 0; i < 5; i++) step(0, 1, byte'(8'h10 + i), 0, 2'b00);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 2'b00);
    step(0, 0, 0, 0, 2'b00);
    check("R5", "no flag mid half", int'(drained), 0);
    // R8: flush mid half, then refill from slot 0
    step(1, 0, 0, 0, 2'b00);
    // R3: fill 16 plus one extra, plus write+read while full
    for (int i = 0; i < 17; i++) step(0, 1, byte'(8'hA0 + i), 0, 2'b00);
    step(0, 1, 8'hEE, 1, 2'b00);
    step(0, 0, 0, 0, 2'b00);
    check("R3", "overflow sticky", int'(overflow), 1);
    check("R3", "count after full wr+rd", int'(count), 15);
    // R7: drain 7 more -> half 0 completes
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 2'b00);
    step(0, 0, 0, 0, 2'b00);
    check("R7", "first drain half 0", int'(drained), 1);
    // R6: clear bit0 while half 1 sets; then collide set with clear on half 0
    for (int i = 0; i < 7; i++) step(0, 1, byte'(8'h30 + i), 1, 2'b00);
    step(0, 1, 8'h37, 1, 2'b01);
    step(0, 0, 0, 0, 2'b00);
    check("R7", "second drain half 1", int'(drained), 2);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 2'b00);
    step(0, 0, 0, 1, 2'b01);
    step(0, 0, 0, 0, 2'b00);
    check("R6", "set wins over clear", int'(drained), 3);
    step(1, 0, 0, 0, 2'b00);
    step(0, 0, 0, 0, 2'b00);
    check("R8", "flush clears", int'(drained) + int'(overflow) + int'(count), 0);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int wb, rb;
      wb = (ph % 2 == 0) ? 75 : 30;
      rb = (ph % 2 == 0) ? 30 : 75;
      for (int i = 0; i < 100; i++) begin
        step(($urandom % 200) == 0,
             ($urandom % 100) < wb,
             byte'($urandom),
             ($urandom % 100) < rb,
             (($urandom % 8) == 0) ? 2'($urandom) : 2'b00);
      end
    end
    @(negedge clk);
    check_state("final");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule